// File: doc/BRIEF.md
# IQ Sample Nibble Packer

This block sits between a decimator and a host transfer engine. Each time the decimator strobes a new sample pair, it keeps the top four bits of the in-phase word and the top four bits of the quadrature word, with no rounding. It joins the two nibbles into one byte, so every byte carries one complete complex sample and no bits are spent on padding. Pairs of bytes become 16-bit words, and the words collect in an internal packet store.

When 512 bytes (256 words) have been stored, the block stops accepting samples and offers the packet on a valid/ready word stream. It flags the final word of the packet. Once that word is accepted, filling starts again from an empty store. A sample that arrives while a finished packet is still waiting to be read is discarded, and a sticky overrun flag records the loss. A dedicated clear input resets the flag.

Top module: `iq_nibble_packer`

## Requirements
- R1: Each nibble is the four most significant bits of its input word, taken unchanged (bits [15:12] for the default 16-bit width). The lower bits are discarded without rounding, so 16'h0FFF gives nibble 0 and 16'h8000 gives nibble 8.
- R2: In every byte the I nibble sits in bits [7:4] and the Q nibble in bits [3:0], and both come from the same strobe.
- R3: The earlier of two consecutive accepted bytes is placed in out_data[7:0] and the later one in out_data[15:8].
- R4: out_valid stays low while a packet fills, and rises only after exactly 512 samples have been accepted into the packet.
- R5: out_last is high on the 256th word of each packet and on no other word. After that word is accepted, out_valid falls and the next accepted sample becomes byte 0 of a new packet.
- R6: While out_valid is high and out_ready is low, out_data and out_last hold their values and out_valid stays high.
- R7: A sample strobed while out_valid is high is discarded: its data never appears on out_data. The overrun output goes high on the next cycle and stays high until it is cleared.
- R8: A high ovr_clr drops overrun on the next cycle, unless a discarded sample arrives in the same cycle; in that case the flag stays set. ovr_clr has no effect on data or packet counting.
- R9: While rst_n is low, out_valid, out_last and overrun are low and the store is empty. Reset is applied asynchronously and released two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Strobe for a new I/Q sample pair |
| in_i | input | 16 | Signed in-phase sample |
| in_q | input | 16 | Signed quadrature sample |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| out_ready | input | 1 | Downstream accepts the presented word |
| out_valid | output | 1 | A stored packet word is presented |
| out_data | output | 16 | Packed word, earlier byte in the low half |
| out_last | output | 1 | Final word of the packet |
| overrun | output | 1 | Sticky flag: a sample was discarded |

## Verification
The bench feeds inputs whose low bits are all ones next to inputs at the most negative value. A design that rounds, or takes the wrong bit slice, returns nibbles that are off by one or shifted. Every word is compared with a model that tracks byte order and nibble order, so swapped lanes or swapped I/Q would fail on the first word. Samples strobed during the drain phase must vanish from the data and set the flag. A design that stored them, or marked the last word one word early or late, would lose alignment with the model and fail every check after that point. The bench also clears the flag in the same cycle as a drop, which catches a design where clear wins over set.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

  // Buffer phase: a packet is either being filled or being drained.
  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } iqp_phase_e;

  // Number of sample channels packed into one byte (I and Q).
  localparam int unsigned IQP_NUM_CH = 2;

endpackage

// File: rtl/iqp_nibble_trunc.sv
module iqp_nibble_trunc #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned NUM_CH   = 2,
  localparam int unsigned BYTE_W  = NUM_CH * NIB_W
) (
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0] ch_in,
  output logic [BYTE_W-1:0]               byte_out
);

  // Channel 0 lands in the top nibble and the last channel in the bottom one.
  // Only the upper bits are kept; no rounding is applied.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign byte_out[(NUM_CH-c)*NIB_W-1 -: NIB_W] = ch_in[c][SAMPLE_W-1 -: NIB_W];
  end

endmodule

// File: rtl/iqp_word_asm.sv
module iqp_word_asm #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BPW    = 2,
  localparam int unsigned WORD_W = BYTE_W * BPW,
  localparam int unsigned LANE_W = (BPW > 2) ? $clog2(BPW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_out
);

  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(BPW - 1);

  logic [LANE_W-1:0]                lane_q, lane_d;
  logic [BPW-2:0][BYTE_W-1:0]       hold_q, hold_d;

  // Next-state: earlier bytes are held in the low lanes; the last byte
  // completes the word combinationally.
  always_comb begin
    lane_d   = lane_q;
    hold_d   = hold_q;
    word_vld = 1'b0;
    if (acc_en) begin
      if (lane_q == LANE_LAST) begin
        word_vld = 1'b1;
        lane_d   = '0;
      end else begin
        hold_d[lane_q[$clog2(BPW-1+1)-1:0]] = byte_in;
        lane_d = lane_q + 1'b1;
      end
    end
  end

  assign word_out = {byte_in, hold_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      hold_q <= '0;
    end else if (acc_en) begin
      lane_q <= lane_d;
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/iqp_pkt_buf.sv
module iqp_pkt_buf
  import iqp_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned PKT_WORDS = 256,
  localparam int unsigned PTR_W    = $clog2(PKT_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic              filling,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_last
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(PKT_WORDS - 1);

  iqp_phase_e        ph_q, ph_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              ptr_en;
  logic [WORD_W-1:0] mem [PKT_WORDS];

  // One pointer serves both phases: it counts writes while filling and
  // reads while draining, and wraps to zero at each phase change.
  always_comb begin
    ph_d   = ph_q;
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    unique case (ph_q)
      PH_FILL: begin
        if (wr_en) begin
          ptr_en = 1'b1;
          if (ptr_q == PTR_LAST) begin
            ptr_d = '0;
            ph_d  = PH_DRAIN;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      PH_DRAIN: begin
        if (rd_ready) begin
          ptr_en = 1'b1;
          if (ptr_q == PTR_LAST) begin
            ptr_d = '0;
            ph_d  = PH_FILL;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      default: begin
        ph_d  = PH_FILL;
        ptr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_FILL;
      ptr_q <= '0;
    end else if (ptr_en) begin
      ph_q  <= ph_d;
      ptr_q <= ptr_d;
    end
  end

  // Packet storage: data only, no reset needed.
  always_ff @(posedge clk) begin
    if (wr_en && (ph_q == PH_FILL)) begin
      mem[ptr_q] <= wr_data;
    end
  end

  assign filling  = (ph_q == PH_FILL);
  assign rd_valid = (ph_q == PH_DRAIN);
  assign rd_data  = mem[ptr_q];
  assign rd_last  = rd_valid && (ptr_q == PTR_LAST);

endmodule

// File: rtl/iqp_ovr_flag.sv
module iqp_ovr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_d;
  logic flag_en;

  // A set in the same cycle as a clear wins, so no loss goes unreported.
  always_comb begin
    flag_en = set_i || clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (flag_en) begin
      flag_o <= flag_d;
    end
  end

endmodule

// File: rtl/iq_nibble_packer.sv
module iq_nibble_packer
  import iqp_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned OUT_W     = 16,
  parameter int unsigned PKT_BYTES = 512,
  localparam int unsigned BYTE_W    = IQP_NUM_CH * NIB_W,
  localparam int unsigned BPW       = OUT_W / BYTE_W,
  localparam int unsigned PKT_WORDS = PKT_BYTES / BPW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  input  logic                ovr_clr,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_last,
  output logic                overrun
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe_q[1];

  logic [IQP_NUM_CH-1:0][SAMPLE_W-1:0] ch_bus;
  logic [BYTE_W-1:0]                   iq_byte;
  logic                                filling;
  logic                                accept;
  logic                                drop;
  logic                                word_vld;
  logic [OUT_W-1:0]                    word_data;

  assign ch_bus[0] = in_i;
  assign ch_bus[1] = in_q;

  assign accept = in_valid && filling;
  assign drop   = in_valid && !filling;

  iqp_nibble_trunc #(
    .SAMPLE_W (SAMPLE_W),
    .NIB_W    (NIB_W),
    .NUM_CH   (IQP_NUM_CH)
  ) u_trunc (
    .ch_in    (ch_bus),
    .byte_out (iq_byte)
  );

  iqp_word_asm #(
    .BYTE_W (BYTE_W),
    .BPW    (BPW)
  ) u_asm (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .acc_en   (accept),
    .byte_in  (iq_byte),
    .word_vld (word_vld),
    .word_out (word_data)
  );

  iqp_pkt_buf #(
    .WORD_W    (OUT_W),
    .PKT_WORDS (PKT_WORDS)
  ) u_buf (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_en    (word_vld),
    .wr_data  (word_data),
    .rd_ready (out_ready),
    .filling  (filling),
    .rd_valid (out_valid),
    .rd_data  (out_data),
    .rd_last  (out_last)
  );

  iqp_ovr_flag u_ovr (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .set_i  (drop),
    .clr_i  (ovr_clr),
    .flag_o (overrun)
  );

endmodule

// File: rtl/iqp_checker.sv
module iqp_checker #(
  parameter int unsigned PKT_BYTES = 512,
  parameter int unsigned PKT_WORDS = 256,
  parameter int unsigned OUT_W     = 16,
  localparam int unsigned CNT_W    = $clog2(PKT_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             ovr_clr,
  input logic             out_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             out_last,
  input logic             overrun
);

  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] sent_q;

  // Counts samples taken into the current packet and words handed out.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      sent_q <= '0;
    end else begin
      if (out_valid && out_ready && out_last) begin
        acc_q  <= '0;
        sent_q <= '0;
      end else begin
        if (in_valid && !out_valid) acc_q <= acc_q + 1'b1;
        if (out_valid && out_ready) sent_q <= sent_q + 1'b1;
      end
    end
  end

  // R4: the packet is offered only once it holds the full sample count.
  assert_full_packet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (acc_q == CNT_W'(PKT_BYTES)))
    else $error("R4 packet offered early or late");

  // R5: end-of-packet marks exactly the final word.
  assert_last_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (sent_q == CNT_W'(PKT_WORDS - 1))))
    else $error("R5 end-of-packet misplaced");

  // R5: the store returns to filling once the last word is accepted.
  assert_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid)
    else $error("R5 no return to fill");

  // R6: a stalled word holds steady.
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)))
    else $error("R6 stalled output changed");

  // R7: a discarded sample raises the flag.
  assert_drop_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_valid) |=> overrun)
    else $error("R7 flag not set on drop");

  // R7: the flag is sticky without a clear.
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun)
    else $error("R7 flag lost");

  // R8: a clear without a concurrent drop lowers the flag.
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !(in_valid && out_valid)) |=> !overrun)
    else $error("R8 clear ignored");

  // R9: outputs are quiet while reset is held.
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_R9: assert (!out_valid && !out_last && !overrun)
        else $error("R9 outputs active in reset");
    end
  end

endmodule

bind iq_nibble_packer iqp_checker #(
  .PKT_BYTES (PKT_BYTES),
  .PKT_WORDS (PKT_WORDS),
  .OUT_W     (OUT_W)
) u_iqp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .ovr_clr   (ovr_clr),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last),
  .overrun   (overrun)
);

// File: tb/test_iq_nibble_packer.sv
`timescale 1ns/1ps
module test_iq_nibble_packer;

  localparam int PKT_BYTES = 512;
  localparam int PKT_WORDS = 256;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_i;
  logic [15:0] in_q;
  logic        ovr_clr;
  logic        out_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_last;
  logic        overrun;

  iq_nibble_packer i_iq_nibble_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .ovr_clr   (ovr_clr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .overrun   (overrun)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // Reference model state
  logic [15:0] exp_q[$];
  logic [7:0]  m_low;
  bit          m_half  = 0;
  int          m_bytes = 0;
  int          m_sent  = 0;
  bit          m_drain = 0;
  bit          m_ovr   = 0;

  function automatic logic [7:0] exp_byte(logic [15:0] i, logic [15:0] q);
    return {i[15:12], q[15:12]};   // R1 top bits, R2 I high / Q low
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge: checks outputs, drives inputs, advances the model,
  // then waits one full cycle to the next negedge.
  task automatic step(bit v, logic [15:0] i, logic [15:0] q, bit rdy, bit clr);
    bit nd;
    check("R4 out_valid phase", 32'(out_valid), 32'(m_drain));
    check("R7 R8 overrun flag", 32'(overrun), 32'(m_ovr));
    if (out_valid && m_drain && exp_q.size() > 0) begin
      check("R1 R2 R3 packed word", 32'(out_data), 32'(exp_q[0]));
      check("R5 out_last", 32'(out_last), 32'(m_sent == PKT_WORDS - 1));
    end
    in_valid  = v;
    in_i      = i;
    in_q      = q;
    out_ready = rdy;
    ovr_clr   = clr;
    nd = m_drain;
    if (v && !m_drain) begin
      logic [7:0] b;
      b = exp_byte(i, q);
      if (!m_half) begin
        m_low  = b;
        m_half = 1;
      end else begin
        exp_q.push_back({b, m_low});
        m_half = 0;
      end
      if (m_bytes == PKT_BYTES - 1) begin
        m_bytes = 0;
        nd = 1;
      end else begin
        m_bytes++;
      end
    end
    if (v && m_drain) m_ovr = 1;
    else if (clr)     m_ovr = 0;
    if (m_drain && rdy) begin
      void'(exp_q.pop_front());
      if (m_sent == PKT_WORDS - 1) begin
        m_sent = 0;
        nd = 0;
      end else begin
        m_sent++;
      end
    end
    m_drain = nd;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Directed corner samples for the start of each packet (R1 truncation).
  function automatic logic [31:0] corner(int k);
    case (k)
      0: return {16'h0FFF, 16'h8000};
      1: return {16'h7FFF, 16'hF000};
      2: return {16'hFFFF, 16'h0000};
      3: return {16'h8001, 16'h7000};
      4: return {16'h1234, 16'hEDCB};
      default: return {16'h9FFF, 16'h6FFF};
    endcase
  endfunction

  task automatic fill_packet(int p);
    for (int k = 0; k < PKT_BYTES; k++) begin
      logic [31:0] s;
      int gap;
      s   = (k < 6) ? corner(k) : $urandom;
      gap = (p == 0) ? 3 : int'($urandom_range(0, 3));
      for (int g = 0; g < gap; g++) begin
        // R8: a clear while filling must not disturb data or counting
        step(0, 16'hAAAA, 16'h5555, $urandom_range(0, 1) == 1,
             (p == 1) && ($urandom_range(0, 7) == 0));
      end
      step(1, s[31:16], s[15:0], $urandom_range(0, 1) == 1, 0);
    end
  endtask

  task automatic drain_packet(int p);
    int n;
    n = 0;
    while (m_drain) begin
      bit v;
      bit clr;
      // R7: strobes during drain are dropped
      v   = (p >= 1) && ($urandom_range(0, 7) == 0);
      clr = 0;
      // R8: clear coinciding with a drop keeps the flag set
      if (p == 3 && n == 20) begin
        v   = 1;
        clr = 1;
      end
      step(v, 16'($urandom), 16'($urandom), $urandom_range(0, 2) != 0, clr);
      n++;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_i      = '0;
    in_q      = '0;
    ovr_clr   = 1'b0;
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9 out_valid in reset", 32'(out_valid), 0);
    check("R9 overrun in reset", 32'(overrun), 0);
    check("R9 out_last in reset", 32'(out_last), 0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      @(negedge clk);
    end
    check("R9 out_valid after release", 32'(out_valid), 0);

    for (int p = 0; p < 4; p++) begin
      fill_packet(p);
      drain_packet(p);
      if (p == 2) begin
        // R8: explicit clear between packets
        step(0, 16'h0, 16'h0, 0, 1);
        step(0, 16'h0, 16'h0, 0, 0);
      end
    end
    step(0, 16'h0, 16'h0, 0, 0);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd150000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule